// File: doc/BRIEF.md
# Post-Increment Load/Store Unit

This unit carries out register-indirect memory instructions whose base register moves forward after the access. A decoder hands it one instruction at a time. Each instruction names a direction (load or store), an access size (32-bit word or 16-bit halfword), a base register, a data register, and an immediate with its encoded length. The unit owns a sixteen-entry register file. It sends exactly one request on a valid/ready memory bus, with the untouched base register value as the address. For a load, it waits for the read response and writes the data into the data register. In every case it then adds the sign-extended immediate to the base register.

The step that advances the base comes from the immediate, not from the access size. A program can therefore walk a buffer forward or backward with any stride in a single instruction. When a load targets its own base register, the loaded value wins over the increment. A one-cycle `done` pulse marks the point where all register writes of the instruction are visible to the next instruction.

Top module: `postinc_mem_unit`

## Requirements
- R1: After reset all sixteen registers read as zero. `instr_ready` is high, and `mem_req_valid` and `done` are low.
- R2: The memory address of every access equals the base register value before the instruction, with no displacement added.
- R3: With `imm_len` = 0, bits 7:0 of `imm` are sign-extended to 32 bits, and the result is added to the base register after the access.
- R4: With `imm_len` = 1, bits 23:0 of `imm` are sign-extended to 32 bits, and the result is added to the base register.
- R5: With `imm_len` = 2 or 3, all 32 bits of `imm` are added to the base register unchanged.
- R6: A store drives `mem_we` = 1 and puts the data register on `mem_wdata`. A word store sends all 32 bits with `mem_half` = 0. A halfword store sends bits 15:0 with bits 31:16 zero and `mem_half` = 1.
- R7: A halfword load (`size_half` = 1) writes `mem_rdata[15:0]` zero-extended to 32 bits. A word load writes all 32 bits.
- R8: When a load's data register and base register are the same, that register ends up holding the loaded value, not the incremented base.
- R9: `done` is high for exactly one cycle. For a store it rises in the cycle after the request handshake; for a load, in the cycle after the response. Every register write of the instruction is visible to the next accepted instruction.
- R10: While a request waits for `mem_req_ready`, `mem_req_valid`, `mem_addr` and `mem_wdata` hold steady. `instr_ready` stays low from acceptance until after `done`.
- R11: A store whose data register is also its base register writes the base value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decoded instruction present |
| instr_ready | output | 1 | Unit idle, accepts an instruction |
| op_store | input | 1 | 1 = store, 0 = load |
| size_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| base_idx | input | 4 | Base register index |
| data_idx | input | 4 | Load destination / store source register index |
| imm | input | 32 | Immediate operand |
| imm_len | input | 2 | 0: 8-bit, 1: 24-bit, 2/3: 32-bit immediate |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_half | output | 1 | Request is a halfword access |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Instruction complete, one-cycle pulse |

## Verification
The embedded assertions check the bus protocol on every cycle: a stalled request stays stable, no instruction is taken while one is in flight, `done` lasts one cycle, and `done` only follows a handshake or a response. Other properties depend on the register file's contents over a run of instructions, and only the bench's scenarios can show them. These are the address taken from the old base, the three immediate extensions, halfword zero-extension, the load-over-increment priority, and the old-value store from a shared register. The bench tracks these with a mirror of the register file, and reads registers back through stores.

// File: rtl/postinc_mem_unit.sv
module postinc_mem_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG),
  localparam int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic            op_store,
  input  logic            size_half,
  input  logic [RIDX-1:0] base_idx,
  input  logic [RIDX-1:0] data_idx,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      imm_len,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_we,
  output logic            mem_half,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} state_t;

  state_t          state;
  logic [XLEN-1:0] rf [NREG];
  logic            st_q, hf_q;
  logic [RIDX-1:0] bidx_q, didx_q;
  logic [XLEN-1:0] addr_q, step_q, wdata_q;

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v, input logic [1:0] l);
    case (l)
      2'd0:    return {{(XLEN-8){v[7]}}, v[7:0]};
      2'd1:    return {{(XLEN-24){v[23]}}, v[23:0]};
      default: return v;
    endcase
  endfunction

  wire [XLEN-1:0] src_val  = rf[data_idx];
  wire [XLEN-1:0] next_base = addr_q + step_q;
  wire [XLEN-1:0] load_val = hf_q ? {{HALF{1'b0}}, mem_rdata[HALF-1:0]} : mem_rdata;

  assign instr_ready   = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_we        = st_q;
  assign mem_half      = hf_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;
  assign done          = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      st_q    <= 1'b0;
      hf_q    <= 1'b0;
      bidx_q  <= '0;
      didx_q  <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      wdata_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (instr_valid) begin
          st_q    <= op_store;
          hf_q    <= size_half;
          bidx_q  <= base_idx;
          didx_q  <= data_idx;
          addr_q  <= rf[base_idx];
          step_q  <= widen(imm, imm_len);
          wdata_q <= size_half ? {{HALF{1'b0}}, src_val[HALF-1:0]} : src_val;
          state   <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          if (st_q) begin
            rf[bidx_q] <= next_base;
            state      <= S_DONE;
          end else begin
            state <= S_RSP;
          end
        end
        S_RSP: if (mem_rsp_valid) begin
          rf[bidx_q] <= next_base;
          rf[didx_q] <= load_val;
          state      <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata)));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !instr_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && instr_ready));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mem_req_valid && mem_req_ready && mem_we) || $past(mem_rsp_valid)));

endmodule

// File: tb/test_postinc_mem_unit.sv
`timescale 1ns/1ps
module test_postinc_mem_unit;
  logic        clk = 0, rst_n = 0;
  logic        instr_valid = 0, op_store = 0, size_half = 0;
  logic [3:0]  base_idx = 0, data_idx = 0;
  logic [31:0] imm = 0, mem_rdata = 0;
  logic [1:0]  imm_len = 0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic        instr_ready, mem_req_valid, mem_we, mem_half, done;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  postinc_mem_unit i_postinc_mem_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .op_store(op_store), .size_half(size_half), .base_idx(base_idx), .data_idx(data_idx),
    .imm(imm), .imm_len(imm_len), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] stride(input logic [31:0] v, input logic [1:0] l);
    if (l == 2'd0) return {{24{v[7]}}, v[7:0]};
    if (l == 2'd1) return {{8{v[23]}}, v[23:0]};
    return v;
  endfunction

  task automatic exec(input bit st, input bit hf, input logic [3:0] b, input logic [3:0] d,
                      input logic [31:0] im, input logic [1:0] ln, input logic [31:0] rd, input int stall);
    logic [31:0] e_addr, e_wdata;
    e_addr  = model[b];
    e_wdata = hf ? {16'h0, model[d][15:0]} : model[d];
    @(negedge clk);
    chk(instr_ready == 1'b1, "R10 ready before issue", {31'b0, instr_ready}, 32'd1);
    instr_valid = 1; op_store = st; size_half = hf; base_idx = b; data_idx = d; imm = im; imm_len = ln;
    @(negedge clk);
    instr_valid = 0;
    for (int k = 0; k < stall; k++) begin
      chk(mem_req_valid && mem_addr == e_addr, "R10 request held", mem_addr, e_addr);
      @(negedge clk);
    end
    chk(mem_req_valid == 1'b1, "R10 request valid", {31'b0, mem_req_valid}, 32'd1);
    chk(instr_ready == 1'b0, "R10 busy", {31'b0, instr_ready}, 32'd0);
    chk(mem_addr == e_addr, "R2 address is old base", mem_addr, e_addr);
    chk(mem_we == st, "R6 write flag", {31'b0, mem_we}, {31'b0, st});
    chk(mem_half == hf, "R6 size flag", {31'b0, mem_half}, {31'b0, hf});
    if (st) chk(mem_wdata == e_wdata, "R6 R11 store data", mem_wdata, e_wdata);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    if (!st) begin
      chk(done == 1'b0, "R9 no done before response", {31'b0, done}, 32'd0);
      mem_rsp_valid = 1; mem_rdata = rd;
      @(negedge clk);
      mem_rsp_valid = 0;
    end
    chk(done == 1'b1, "R9 done pulse", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0 && instr_ready, "R9 done single cycle", {31'b0, done}, 32'd0);
    model[b] = model[b] + stride(im, ln);
    if (!st) model[d] = hf ? {16'h0, rd[15:0]} : rd;
  endtask

  task automatic peek(input logic [3:0] r, input logic [31:0] exp, input string tag);
    exec(1'b1, 1'b0, 4'd15, r, 32'h0, 2'd0, 32'h0, 0);
    chk(mem_wdata == exp, tag, mem_wdata, exp);
  endtask

  typedef struct packed {
    logic st; logic hf; logic [3:0] b; logic [3:0] d;
    logic [31:0] im; logic [1:0] ln; logic [31:0] rd; logic [3:0] stall;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 4'd2, 4'd1, 32'h0000_0004, 2'd0, 32'h1000_0000, 4'd0},
    '{1'b0, 1'b0, 4'd1, 4'd3, 32'h0000_00F0, 2'd0, 32'hDEAD_BEEF, 4'd2},
    '{1'b0, 1'b1, 4'd2, 4'd4, 32'h0080_0000, 2'd1, 32'hABCD_1234, 4'd1},
    '{1'b1, 1'b0, 4'd4, 4'd3, 32'h1234_5678, 2'd2, 32'h0,         4'd0},
    '{1'b1, 1'b1, 4'd1, 4'd3, 32'h00FF_FFFF, 2'd1, 32'h0,         4'd3},
    '{1'b0, 1'b0, 4'd5, 4'd5, 32'h0000_0008, 2'd0, 32'h0000_0055, 4'd0},
    '{1'b1, 1'b0, 4'd1, 4'd1, 32'h0000_007F, 2'd0, 32'h0,         4'd1},
    '{1'b0, 1'b1, 4'd6, 4'd6, 32'hFFFF_FF80, 2'd3, 32'h8000_9ABC, 4'd0}
  };

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(instr_ready == 1'b1, "R1 ready after reset", {31'b0, instr_ready}, 32'd1);
    chk(mem_req_valid == 1'b0 && done == 1'b0, "R1 idle bus after reset", {30'b0, mem_req_valid, done}, 32'd0);
    for (int r = 0; r < 16; r++) peek(r[3:0], 32'h0, "R1 register zero after reset");

    for (int v = 0; v < 8; v++)
      exec(VECS[v].st, VECS[v].hf, VECS[v].b, VECS[v].d, VECS[v].im, VECS[v].ln, VECS[v].rd, int'(VECS[v].stall));
    for (int r = 0; r < 15; r++) peek(r[3:0], model[r], "R9 committed registers");

    // Directed values, computed by hand
    peek(4'd1, 32'h1000_006E, "R3 R4 R11 base after imm8 -16, imm24 -1, +0x7F");
    peek(4'd2, 32'hFF80_0004, "R3 R4 base after +4 then imm24 0x800000");
    peek(4'd3, 32'hDEAD_BEEF, "R7 word load full width");
    peek(4'd4, 32'h1234_68AC, "R5 R7 halfword load zero-extend plus imm32");
    peek(4'd5, 32'h0000_0055, "R8 load wins over increment");
    peek(4'd6, 32'h0000_9ABC, "R7 R8 halfword load into base register");

    // R11 store from shared register sends pre-increment value, then R3 negative imm8 boundary
    exec(1'b1, 1'b0, 4'd7, 4'd7, 32'h0000_0080, 2'd0, 32'h0, 2);
    chk(mem_wdata == 32'h0, "R11 old base stored", mem_wdata, 32'h0);
    peek(4'd7, 32'hFFFF_FF80, "R3 imm8 0x80 is -128");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule